// File: doc/BRIEF.md
# Edge-Selectable Retriggerable One-Shot

This block is a clocked pulse stretcher. A qualified transition on its trigger input, or a rising transition on a separate fast input, starts an output pulse. A second qualified transition arriving while the pulse is still running restarts the timing. The result is a pulse that ends one full width after the most recent accepted trigger.

A two-bit edge-select code chooses which trigger transitions count: rising, falling, both, or none. The pulse length is not loaded as a count. A timing accumulator is filled with a fixed full-scale swing and drained by a programmable rate on every clock. The width is therefore the swing divided by the rate, rounded up, and never less than one clock.

An optional lockout mode feeds the running pulse back so that trigger transitions arriving during it are ignored. A zero rate is clamped to one and recorded in a sticky fault flag. All asynchronous inputs pass through a two-flop synchronizer before edge detection. The enable code passes through the same pipeline, so it stays aligned with the trigger it qualifies.

Top module: `retrig_oneshot`

## Requirements
- R1: The code edge_sel selects trigger edges. Bit 1 is the rise-only select and bit 0 is the fall-only select. 2'b00 accepts both rising and falling transitions of trig_in, 2'b10 accepts rising only, 2'b01 accepts falling only, and 2'b11 ignores trig_in entirely.
- R2: An accepted trigger while pulse_q is high reloads the full swing. pulse_q then stays high continuously until one full width after that latest trigger.
- R3: Once started, pulse_q stays high for ceil(FULL_SWING / rate) clocks (FULL_SWING = 190 by default), with a minimum of one clock when rate exceeds the swing.
- R4: A rising transition of fast_in starts or restarts a pulse whatever the value of edge_sel. A falling transition of fast_in has no effect.
- R5: With lock_mode high, trig_in transitions that are detected while pulse_q is high are dropped. The running pulse ends on its original schedule, and a transition after the pulse ends is accepted normally.
- R6: pulse_qn is always the complement of pulse_q, and pulse_q is low when no pulse runs.
- R7: A rate of 0 is timed as a rate of 1. It also sets rate_fault one clock later, and rate_fault stays set until reset.
- R8: pulse_q first reads high after the third rising clock edge that follows a change on trig_in or fast_in. The first edge that samples the new level counts as the first.
- R9: After reset, pulse_q is low, rate_fault is low and the accumulator is empty. A level held on trig_in across reset release starts no pulse.
- R10: edge_sel is sampled through the same synchronizer as trig_in. A value held from one clock before a trigger transition to one clock after it qualifies that transition. A change made one clock before the transition governs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger input, qualified by edge_sel |
| fast_in | input | 1 | Asynchronous fast trigger, rising edge only |
| edge_sel | input | 2 | Edge selection code (see R1) |
| lock_mode | input | 1 | 1 = non-retriggerable for trig_in |
| rate | input | RATE_W (8) | Accumulator drain per clock |
| pulse_q | output | 1 | True output |
| pulse_qn | output | 1 | Complementary output |
| rate_fault | output | 1 | Sticky flag, set by a zero rate |

## Verification
The assertions take the synchronized levels and rate as given each cycle. They assume nothing about setup, but the width and restart properties are only meaningful when rate is held steady across a pulse. The stimulus therefore sets rate and edge_sel several clocks before each trigger and changes them only after the pulse has finished. The one exception is the enable-window test, which deliberately moves edge_sel exactly one clock after or one clock before a transition. All inputs are driven on the falling clock edge, away from the sampling edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Edge selection code: bit 1 = rise-only select, bit 0 = fall-only select
    typedef enum logic [1:0] {
        EDGE_BOTH = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/os_sync_pipe.sv
module os_sync_pipe #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         valid
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [STAGES-1:0]        fill;
    } pipe_t;

    pipe_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.chain[0] = din;
        nxt_d.fill[0]  = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            nxt_d.chain[i] = cur_q.chain[i-1];
            nxt_d.fill[i]  = cur_q.fill[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dout  = cur_q.chain[STAGES-1];
    assign valid = cur_q.fill[STAGES-1];

    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid); // R9

endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
    import oneshot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_valid,
    input  logic       trig_lvl,
    input  logic       fast_lvl,
    input  logic [1:0] sel,
    input  logic       lock_en,
    input  logic       busy,
    output logic       trig_go,
    output logic       fast_go,
    output logic       fire
);

    typedef struct packed {
        logic prev_trig;
        logic prev_fast;
        logic armed;
    } qual_t;

    qual_t cur_q, nxt_d;
    logic  rise_w, fall_w, hit_w;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.prev_trig = trig_lvl;
        nxt_d.prev_fast = fast_lvl;
        nxt_d.armed     = cur_q.armed | lvl_valid;

        rise_w = trig_lvl & ~cur_q.prev_trig;
        fall_w = ~trig_lvl & cur_q.prev_trig;

        unique case (edge_mode_e'(sel))
            EDGE_BOTH: hit_w = rise_w | fall_w;
            EDGE_RISE: hit_w = rise_w;
            EDGE_FALL: hit_w = fall_w;
            EDGE_NONE: hit_w = 1'b0;
            default:   hit_w = 1'b0;
        endcase

        trig_go = cur_q.armed & hit_w & ~(lock_en & busy);
        fast_go = cur_q.armed & fast_lvl & ~cur_q.prev_fast;
        fire    = trig_go | fast_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |-> !trig_go); // R1
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == EDGE_RISE) && trig_go) |-> trig_lvl); // R1
    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == EDGE_FALL) && trig_go) |-> !trig_lvl); // R1
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && busy) |-> !trig_go); // R5
    AST_FAST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_go |-> (fast_lvl && !$past(fast_lvl))); // R4

endmodule

// File: rtl/os_width_timer.sv
module os_width_timer #(
    parameter int FULL_SWING = 190,
    parameter int RATE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate,
    output logic              active,
    output logic              rate_err
);

    localparam int ACC_W = $clog2(FULL_SWING + 1);
    localparam int CMP_W = (ACC_W > RATE_W) ? ACC_W : RATE_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             act;
        logic             err;
    } tmr_t;

    tmr_t              cur_q, nxt_d;
    logic [RATE_W-1:0] rate_eff;
    logic              rate_zero;

    always_comb begin
        rate_zero = (rate == '0);
        rate_eff  = rate_zero ? RATE_W'(1) : rate;

        nxt_d     = cur_q;
        nxt_d.err = cur_q.err | rate_zero;

        if (start) begin
            nxt_d.acc = ACC_W'(FULL_SWING);
            nxt_d.act = 1'b1;
        end else if (cur_q.act) begin
            if (CMP_W'(cur_q.acc) <= CMP_W'(rate_eff)) begin
                nxt_d.acc = '0;
                nxt_d.act = 1'b0;
            end else begin
                nxt_d.acc = ACC_W'(CMP_W'(cur_q.acc) - CMP_W'(rate_eff));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign active   = cur_q.act;
    assign rate_err = cur_q.err;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_q.act && (cur_q.acc == ACC_W'(FULL_SWING)))); // R2
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.act |-> (cur_q.acc == '0)); // R9
    AST_DRAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.act && !start) |=> (cur_q.acc < $past(cur_q.acc))); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.err |=> cur_q.err); // R7
    AST_ZERO_RATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |=> cur_q.err); // R7

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot #(
    parameter int FULL_SWING  = 190,
    parameter int RATE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              fast_in,
    input  logic [1:0]        edge_sel,
    input  logic              lock_mode,
    input  logic [RATE_W-1:0] rate,
    output logic              pulse_q,
    output logic              pulse_qn,
    output logic              rate_fault
);

    localparam int PIPE_W = 4;

    logic [PIPE_W-1:0] raw_w, sync_w;
    logic              sync_valid;
    logic              trig_go_w, fast_go_w, start_w, active_w;

    assign raw_w = {edge_sel, fast_in, trig_in};

    os_sync_pipe #(
        .W      (PIPE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_w),
        .dout  (sync_w),
        .valid (sync_valid)
    );

    os_edge_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_valid (sync_valid),
        .trig_lvl  (sync_w[0]),
        .fast_lvl  (sync_w[1]),
        .sel       (sync_w[3:2]),
        .lock_en   (lock_mode),
        .busy      (active_w),
        .trig_go   (trig_go_w),
        .fast_go   (fast_go_w),
        .fire      (start_w)
    );

    os_width_timer #(
        .FULL_SWING (FULL_SWING),
        .RATE_W     (RATE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .rate     (rate),
        .active   (active_w),
        .rate_err (rate_fault)
    );

    assign pulse_q  = active_w;
    assign pulse_qn = ~active_w;

    AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> pulse_q); // R2
    AST_FAST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        fast_go_w |=> pulse_q); // R4
    AST_LOCK_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode && pulse_q) |-> !trig_go_w); // R5

endmodule

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

    localparam int SWING = 190;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trig_in, fast_in, lock_mode;
    logic [1:0] edge_sel;
    logic [7:0] rate;
    logic       pulse_q, pulse_qn, rate_fault;

    int  nchk = 0;
    int  nerr = 0;
    int  cyc  = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    retrig_oneshot u_retrig_oneshot (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .fast_in    (fast_in),
        .edge_sel   (edge_sel),
        .lock_mode  (lock_mode),
        .rate       (rate),
        .pulse_q    (pulse_q),
        .pulse_qn   (pulse_qn),
        .rate_fault (rate_fault)
    );

    // {edge_sel[1:0], new trig level, expect fire, rate[7:0]}
    localparam logic [11:0] VEC [11] = '{
        {2'b00, 1'b1, 1'b1, 8'd190},
        {2'b00, 1'b0, 1'b1, 8'd100},
        {2'b10, 1'b1, 1'b1, 8'd95},
        {2'b10, 1'b0, 1'b0, 8'd60},
        {2'b01, 1'b0, 1'b1, 8'd50},
        {2'b01, 1'b1, 1'b0, 8'd50},
        {2'b11, 1'b1, 1'b0, 8'd20},
        {2'b11, 1'b0, 1'b0, 8'd20},
        {2'b00, 1'b1, 1'b1, 8'd255},
        {2'b10, 1'b1, 1'b1, 8'd19},
        {2'b01, 1'b0, 1'b1, 8'd7}
    };

    function automatic int width_of(input int r);
        int re = (r == 0) ? 1 : r;
        return (SWING + re - 1) / re;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic observe(output int lat, output int wid, output int pair_bad);
        lat = 0; wid = 0; pair_bad = 0;
        for (int n = 1; n <= 12 && lat == 0; n++) begin
            @(negedge clk);
            if (pulse_qn == pulse_q) pair_bad++;
            if (pulse_q) lat = n;
        end
        if (lat != 0) begin
            wid = 1;
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                if (pulse_qn == pulse_q) pair_bad++;
                if (pulse_q) wid++;
                else break;
            end
        end
    endtask

    task automatic arm(input logic [1:0] sel, input logic lvl);
        edge_sel = 2'b11;
        trig_in  = lvl;
        repeat (6) @(negedge clk);
        edge_sel = sel;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int lat, wid, pb, cnt;
        rst_n = 1'b0; trig_in = 1'b1; fast_in = 1'b0;
        edge_sel = 2'b00; lock_mode = 1'b0; rate = 8'd50;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, level held across reset starts nothing
        @(negedge clk);
        check(pulse_q == 1'b0, "R9 q after reset", pulse_q, 0);
        check(pulse_qn == 1'b1, "R6 qn after reset", pulse_qn, 1);
        check(rate_fault == 1'b0, "R9 fault after reset", rate_fault, 0);
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (pulse_q) cnt++;
        end
        check(cnt == 0, "R9 no pulse from held level", cnt, 0);

        // R1 R3 R8 R6: table walk
        foreach (VEC[i]) begin
            logic [11:0] v = VEC[i];
            int exp_w = v[8] ? width_of(int'(v[7:0])) : 0;
            rate = v[7:0];
            arm(v[11:10], ~v[9]);
            trig_in = v[9];
            observe(lat, wid, pb);
            check(lat == (v[8] ? 3 : 0), "R1/R8 latency", lat, v[8] ? 3 : 0);
            check(wid == exp_w, "R3 width", wid, exp_w);
            check(pb == 0, "R6 complement", pb, 0);
        end

        // R2: retrigger on falling edge in both-edge mode
        rate = 8'd10;
        arm(2'b00, 1'b0);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pulse_q == 1'b1, "R2 first pulse up", pulse_q, 1);
        repeat (8) @(negedge clk);
        trig_in = 1'b0;
        cnt = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (pulse_q) cnt++;
            else break;
        end
        check(cnt == 2 + width_of(10), "R2 restart extends", cnt, 2 + width_of(10));

        // R5: lockout drops edges during the pulse
        lock_mode = 1'b1;
        arm(2'b00, 1'b0);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        repeat (5) @(negedge clk);
        trig_in = 1'b0;
        cnt = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (pulse_q) cnt++;
            else break;
        end
        check(cnt == width_of(10) - 6, "R5 original end kept", cnt, width_of(10) - 6);
        cnt = 0;
        repeat (12) begin
            @(negedge clk);
            if (pulse_q) cnt++;
        end
        check(cnt == 0, "R5 no late pulse", cnt, 0);
        trig_in = 1'b1;
        observe(lat, wid, pb);
        check(wid == width_of(10), "R5 edge after pulse accepted", wid, width_of(10));
        lock_mode = 1'b0;

        // R4: fast input rises bypass disabled trigger; falling ignored
        rate = 8'd38;
        arm(2'b11, trig_in);
        fast_in = 1'b1;
        observe(lat, wid, pb);
        check(lat == 3, "R4 fast latency", lat, 3);
        check(wid == width_of(38), "R4 fast width", wid, width_of(38));
        fast_in = 1'b0;
        observe(lat, wid, pb);
        check(wid == 0, "R4 fast fall ignored", wid, 0);

        // R7: zero rate clamps and sets sticky fault
        rate = 8'd0;
        arm(2'b10, 1'b0);
        check(rate_fault == 1'b1, "R7 fault set", rate_fault, 1);
        trig_in = 1'b1;
        observe(lat, wid, pb);
        check(wid == SWING, "R7 clamped width", wid, SWING);
        rate = 8'd50;
        arm(2'b10, 1'b0);
        trig_in = 1'b1;
        observe(lat, wid, pb);
        check(wid == width_of(50), "R7 width after fix", wid, width_of(50));
        check(rate_fault == 1'b1, "R7 fault sticky", rate_fault, 1);

        // R10: select held one clock after the edge still qualifies
        arm(2'b10, 1'b0);
        trig_in = 1'b1;
        @(negedge clk);
        edge_sel = 2'b11;
        observe(lat, wid, pb);
        check(lat == 2, "R10 hold window latency", lat, 2);
        check(wid == width_of(50), "R10 hold window width", wid, width_of(50));

        // R10: select changed one clock before the edge governs it
        arm(2'b10, 1'b0);
        edge_sel = 2'b11;
        @(negedge clk);
        trig_in = 1'b1;
        observe(lat, wid, pb);
        check(wid == 0, "R10 late disable honoured", wid, 0);

        finish_run();
    end

endmodule